// File: doc/BRIEF.md
# Erased Sector Detector

This block sits beside a sector error decoder. When the decoder gives up on a sector because it found more errors than it can repair, the sector may not be damaged data at all: it may be a freshly erased sector, all ones, in which a handful of cells have drifted to zero. The detector tells these two cases apart. Software or a sequencer replays the sector into it as a byte stream: first the 512 payload bytes, then the 13 stored code bytes, one byte per cycle in which `byte_valid` is high.

Every byte contributes the number of its bits that read as zero. The payload zeros and the code zeros are tallied in two separate counters. Each counter stops growing once it passes the repair limit of 8, so neither can wrap. One cycle after the final code byte the block raises a one-cycle verdict. The verdict is either "erased", with the total zero count and a request to overwrite the payload with 0xFF when the payload itself held any zero, or "uncorrectable".

A sector starts with a one-cycle `sector_start` pulse that also carries the decoder's error count. When that count is 8 or less, the decoder has already repaired the sector, so the detector stays idle and produces no verdict.

The controller has four states. `ST_IDLE` waits for a start pulse. `ST_DATA` counts payload bytes. `ST_CHECK` counts code bytes. `ST_REPORT` presents the verdict for one cycle. The transitions are:
- *arm*: `ST_IDLE` to `ST_DATA`, on a start pulse whose error count exceeds 8.
- *data_done*: `ST_DATA` to `ST_CHECK`, on the 512th payload byte.
- *check_done*: `ST_CHECK` to `ST_REPORT`, on the 13th code byte.
- *report_done*: `ST_REPORT` to `ST_IDLE`.
- *restart*: any state goes to `ST_DATA` on an armed start pulse.
- *disarm*: any state goes to `ST_IDLE` on an unarmed start pulse.

Top module: `erased_sector_detector`

## Requirements
- R1: After reset, `verdict_valid`, `verdict_erased`, `verdict_fail`, `fill_ones` and `zero_bits` are all 0, and the block waits in `ST_IDLE`.
- R2: A `sector_start` pulse with `fail_errs` of 8 or less disarms the block. Bytes that follow it produce no verdict until the next armed start pulse.
- R3: Each accepted byte adds the count of its zero bits, which is the population count of the inverted byte. Each of the two tallies saturates at 9 and never exceeds it.
- R4: After an armed start, the first 512 cycles with `byte_valid` high carry payload bytes and the next 13 carry code bytes. Cycles with `byte_valid` low, and the start cycle itself, add nothing.
- R5: `verdict_valid` is high for exactly one cycle: the cycle after the clock edge that accepts the 525th byte.
- R6: When payload zeros plus code zeros total 8 or fewer, the verdict has `verdict_erased`=1, `verdict_fail`=0, and `zero_bits` equal to that total.
- R7: On an erased verdict, `fill_ones` is 1 if the payload bytes held at least one zero bit, and 0 if every payload byte was 0xFF, even when the code bytes held zeros.
- R8: When the total exceeds 8, the verdict has `verdict_fail`=1, `verdict_erased`=0, `fill_ones`=0 and `zero_bits`=9.
- R9: A `sector_start` pulse in the middle of a sector abandons that sector. Both tallies clear, and counting starts again from the first payload byte.
- R10: `verdict_erased` and `verdict_fail` are never both high, and outside the verdict cycle all verdict outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sector_start | input | 1 | One-cycle pulse that opens a sector; the byte lane is ignored in this cycle |
| fail_errs | input | ERR_W (5) | Error count from the decoder, sampled with `sector_start` |
| byte_valid | input | 1 | Marks `byte_data` as a sector byte |
| byte_data | input | BYTE_W (8) | Sector byte stream: payload first, then code bytes |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_erased | output | 1 | Sector judged erased |
| verdict_fail | output | 1 | Sector judged uncorrectable |
| fill_ones | output | 1 | Payload must be overwritten with 0xFF |
| zero_bits | output | $clog2(MAX_FLIPS+2) (4) | Zero-bit total on an erased verdict; 9 on failure |

## Verification
A wrong state shows up as a verdict pulse in the wrong cycle. A byte counter that is off by one, or a missed `byte_valid` gap, moves the pulse one cycle early or late, and the bench catches this at the byte where it should appear. A tally that has not been cleared, or that has not saturated, shows up in the same verdict cycle as a wrong `zero_bits` value or a flipped erased/fail decision. Sectors placed at exactly 8 and 9 zeros, and an abandoned sector followed by a clean one, make such a fault visible at the very next verdict.

// File: rtl/esd_pkg.sv
package esd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_CHECK  = 2'd2,
        ST_REPORT = 2'd3
    } esd_state_e;

    localparam int SPAN_DATA  = 0;
    localparam int SPAN_CHECK = 1;
    localparam int NUM_SPANS  = 2;

endpackage

// File: rtl/esd_zero_count.sv
module esd_zero_count #(
    parameter int WIDTH = 8,
    localparam int PC_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] value,
    output logic [PC_W-1:0]  zeros
);
    always_comb begin
        zeros = '0;
        for (int b = 0; b < WIDTH; b++) begin
            zeros = zeros + PC_W'(~value[b]);
        end
    end
endmodule

// File: rtl/esd_sat_tally.sv
module esd_sat_tally #(
    parameter int IN_W  = 4,
    parameter int LIMIT = 9,
    localparam int CNT_W = $clog2(LIMIT + 1),
    localparam int SUM_W = ((CNT_W > IN_W) ? CNT_W : IN_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic [IN_W-1:0]  add_val,
    output logic [CNT_W-1:0] count
);
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(count) + SUM_W'(add_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (add_en) begin
            if (sum > SUM_W'(LIMIT)) begin
                count <= CNT_W'(LIMIT);
            end else begin
                count <= CNT_W'(sum);
            end
        end
    end

    // R3: the tally never climbs past its saturation value
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(LIMIT));

    // R3: once saturated, further bytes cannot move it until cleared
    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(LIMIT) && !clear) |=> count == CNT_W'(LIMIT));

    // R9: a clear always empties the tally
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count == '0);
endmodule

// File: rtl/esd_ctrl_fsm.sv
module esd_ctrl_fsm
    import esd_pkg::*;
#(
    parameter int DATA_BYTES  = 512,
    parameter int CHECK_BYTES = 13,
    localparam int MAX_SPAN   = (DATA_BYTES > CHECK_BYTES) ? DATA_BYTES : CHECK_BYTES,
    localparam int IDX_W      = $clog2(MAX_SPAN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 armed,
    input  logic                 byte_valid,
    output esd_state_e           state,
    output logic [NUM_SPANS-1:0] span_add,
    output logic                 clear,
    output logic                 report
);
    esd_state_e       state_n;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_n;
    logic             last_data;
    logic             last_check;

    always_comb begin
        last_data  = (idx_q == IDX_W'(DATA_BYTES - 1));
        last_check = (idx_q == IDX_W'(CHECK_BYTES - 1));
    end

    // next-state and index logic
    always_comb begin
        state_n = state;
        idx_n   = idx_q;
        if (start) begin
            state_n = armed ? ST_DATA : ST_IDLE;
            idx_n   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_n = ST_IDLE;
                end
                ST_DATA: begin
                    if (byte_valid) begin
                        if (last_data) begin
                            state_n = ST_CHECK;
                            idx_n   = '0;
                        end else begin
                            idx_n = idx_q + 1'b1;
                        end
                    end
                end
                ST_CHECK: begin
                    if (byte_valid) begin
                        if (last_check) begin
                            state_n = ST_REPORT;
                            idx_n   = '0;
                        end else begin
                            idx_n = idx_q + 1'b1;
                        end
                    end
                end
                ST_REPORT: begin
                    state_n = ST_IDLE;
                end
                default: begin
                    state_n = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx_q <= '0;
        end else begin
            state <= state_n;
            idx_q <= idx_n;
        end
    end

    // outputs
    always_comb begin
        span_add = '0;
        clear    = start;
        report   = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_DATA:   span_add[SPAN_DATA]  = byte_valid && !start;
            ST_CHECK:  span_add[SPAN_CHECK] = byte_valid && !start;
            ST_REPORT: report = 1'b1;
            default:   ;
        endcase
    end

    // R5: the report state lasts a single cycle
    p_report_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPORT) |=> (state != ST_REPORT));

    // R2: an unarmed start leaves the block idle
    p_disarm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !armed) |=> (state == ST_IDLE));

    // R4: code bytes are reached only after the full payload
    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && $past(state) != ST_CHECK) |->
            ($past(state) == ST_DATA && $past(byte_valid)));

    // R4: an idle byte lane does not advance the position
    p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid && !start && (state == ST_DATA || state == ST_CHECK)) |=>
            $stable(idx_q));

    // R9: an armed start always restarts at the first payload byte
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && armed) |=> (state == ST_DATA && idx_q == '0));
endmodule

// File: rtl/erased_sector_detector.sv
module erased_sector_detector
    import esd_pkg::*;
#(
    parameter int DATA_BYTES  = 512,
    parameter int CHECK_BYTES = 13,
    parameter int MAX_FLIPS   = 8,
    parameter int BYTE_W      = 8,
    parameter int ERR_W       = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             sector_start,
    input  logic [ERR_W-1:0]                 fail_errs,
    input  logic                             byte_valid,
    input  logic [BYTE_W-1:0]                byte_data,
    output logic                             verdict_valid,
    output logic                             verdict_erased,
    output logic                             verdict_fail,
    output logic                             fill_ones,
    output logic [$clog2(MAX_FLIPS+2)-1:0]   zero_bits
);
    localparam int LIMIT = MAX_FLIPS + 1;
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam int PC_W  = $clog2(BYTE_W + 1);
    localparam int TOT_W = CNT_W + 1;

    esd_state_e           state;
    logic [NUM_SPANS-1:0] span_add;
    logic                 clear;
    logic                 report;
    logic                 armed;
    logic [PC_W-1:0]      byte_zeros;
    logic [CNT_W-1:0]     tally [NUM_SPANS];
    logic [TOT_W-1:0]     total;
    logic                 is_erased;

    always_comb begin
        armed = (fail_errs > ERR_W'(MAX_FLIPS));
    end

    esd_ctrl_fsm #(
        .DATA_BYTES (DATA_BYTES),
        .CHECK_BYTES(CHECK_BYTES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sector_start),
        .armed     (armed),
        .byte_valid(byte_valid),
        .state     (state),
        .span_add  (span_add),
        .clear     (clear),
        .report    (report)
    );

    esd_zero_count #(.WIDTH(BYTE_W)) u_zeros (
        .value(byte_data),
        .zeros(byte_zeros)
    );

    for (genvar g = 0; g < NUM_SPANS; g++) begin : g_span
        esd_sat_tally #(
            .IN_W (PC_W),
            .LIMIT(LIMIT)
        ) u_tally (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (clear),
            .add_en (span_add[g]),
            .add_val(byte_zeros),
            .count  (tally[g])
        );
    end

    always_comb begin
        total     = TOT_W'(tally[SPAN_DATA]) + TOT_W'(tally[SPAN_CHECK]);
        is_erased = (total <= TOT_W'(MAX_FLIPS));
    end

    always_comb begin
        verdict_valid  = report;
        verdict_erased = report && is_erased;
        verdict_fail   = report && !is_erased;
        fill_ones      = report && is_erased && (tally[SPAN_DATA] != '0);
        zero_bits      = '0;
        if (report) begin
            zero_bits = is_erased ? CNT_W'(total) : CNT_W'(LIMIT);
        end
    end

    // R10: at most one verdict kind, and only inside the strobe
    p_one_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({verdict_erased, verdict_fail}) &&
        ((verdict_erased || verdict_fail) == verdict_valid));

    // R5: the strobe is a single-cycle pulse
    p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);

    // R7: overwrite is requested only for an erased sector
    p_fill_erased_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ones |-> verdict_erased);

    // R8: a failed sector reports the saturated count
    p_fail_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_fail |-> (zero_bits == CNT_W'(LIMIT) && !fill_ones));

    // R6: an erased verdict never claims more flips than the limit
    p_erased_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_erased |-> (zero_bits <= CNT_W'(MAX_FLIPS)));

    // R1: quiet outputs while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!verdict_valid && zero_bits == '0));
endmodule

// File: tb/erased_sector_detector_bench.sv
module erased_sector_detector_bench;
    localparam int NBYTES = 525;
    localparam int NDATA  = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sector_start = 1'b0;
    logic [4:0] fail_errs = '0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       verdict_valid;
    logic       verdict_erased;
    logic       verdict_fail;
    logic       fill_ones;
    logic [3:0] zero_bits;

    int checks = 0;
    int errors = 0;
    logic [7:0] sec [NBYTES];

    always #4 clk = ~clk;

    erased_sector_detector u_erased_sector_detector (
        .clk           (clk),
        .rst_n         (rst_n),
        .sector_start  (sector_start),
        .fail_errs     (fail_errs),
        .byte_valid    (byte_valid),
        .byte_data     (byte_data),
        .verdict_valid (verdict_valid),
        .verdict_erased(verdict_erased),
        .verdict_fail  (verdict_fail),
        .fill_ones     (fill_ones),
        .zero_bits     (zero_bits)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int zeros_in(input int lo, input int hi);
        int n = 0;
        for (int i = lo; i < hi; i++) begin
            for (int b = 0; b < 8; b++) n += (sec[i][b] == 1'b0) ? 1 : 0;
        end
        return n;
    endfunction

    task automatic fill_sector(input int dflips, input int cflips);
        for (int i = 0; i < NBYTES; i++) sec[i] = 8'hFF;
        for (int k = 0; k < dflips; k++) sec[$urandom_range(NDATA-1, 0)][$urandom_range(7, 0)] = 1'b0;
        for (int k = 0; k < cflips; k++) sec[$urandom_range(NBYTES-1, NDATA)][$urandom_range(7, 0)] = 1'b0;
    endtask

    task automatic pulse_start(input int errs);
        @(negedge clk);
        sector_start = 1'b1;
        fail_errs    = 5'(errs);
        byte_valid   = 1'b0;
        @(negedge clk);
        sector_start = 1'b0;
    endtask

    // streams sec[0:count-1]; sector_start already issued
    task automatic stream(input int count, input int gap_pct, output int spurious);
        spurious = 0;
        for (int i = 0; i < count; i++) begin
            while ($urandom_range(99, 0) < gap_pct) begin
                byte_valid = 1'b0;
                byte_data  = 8'($urandom);
                @(negedge clk);
                if (verdict_valid) spurious++;
            end
            byte_valid = 1'b1;
            byte_data  = sec[i];
            @(negedge clk);
            if (verdict_valid && i != count - 1) spurious++;
        end
        byte_valid = 1'b0;
    endtask

    // full armed sector with verdict checks
    task automatic run_sector(input int errs, input int gap_pct, input string tag);
        int d, c, tot, sp, ez, ef, ezb, efill;
        d   = zeros_in(0, NDATA);
        c   = zeros_in(NDATA, NBYTES);
        tot = d + c;
        ez  = (tot <= 8) ? 1 : 0;
        ef  = 1 - ez;
        ezb = ez ? tot : 9;
        efill = (ez && d > 0) ? 1 : 0;
        pulse_start(errs);
        stream(NBYTES, gap_pct, sp);
        // now one cycle after the accepting edge of the last byte
        chk(sp == 0, {"R4 no early strobe ", tag}, sp, 0);
        chk(verdict_valid == 1'b1, {"R5 strobe after last byte ", tag}, int'(verdict_valid), 1);
        if (ez) begin
            chk(verdict_erased == 1'b1 && verdict_fail == 1'b0, {"R6 erased ", tag}, int'(verdict_erased), 1);
            chk(zero_bits == 4'(tot), {"R6 count ", tag}, int'(zero_bits), tot);
            chk(fill_ones == 1'(efill), {"R7 fill ", tag}, int'(fill_ones), efill);
        end else begin
            chk(verdict_fail == 1'b1 && verdict_erased == 1'b0, {"R8 fail ", tag}, int'(verdict_fail), ef);
            chk(zero_bits == 4'(ezb) && fill_ones == 1'b0, {"R8 count ", tag}, int'(zero_bits), ezb);
        end
        @(negedge clk);
        chk(!verdict_valid && !verdict_erased && !verdict_fail && !fill_ones,
            {"R10 quiet after strobe ", tag}, int'(verdict_valid), 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int sp;
        void'($urandom(32'h5EC7_0A11));
        repeat (3) @(negedge clk);
        chk(!verdict_valid && !verdict_erased && !verdict_fail && !fill_ones && zero_bits == 0,
            "R1 reset outputs", int'(verdict_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!verdict_valid && zero_bits == 0, "R1 after reset release", int'(zero_bits), 0);

        // R6 R7: clean erased sector, nothing to fill
        fill_sector(0, 0);
        run_sector(9, 0, "all ones");
        // R7: zeros only in code bytes -> erased, no fill
        fill_sector(0, 5);
        run_sector(20, 10, "code only");
        // R6: exactly 8 zeros
        fill_sector(0, 0);
        for (int k = 0; k < 8; k++) sec[k * 60][k] = 1'b0;
        run_sector(12, 0, "exactly eight");
        // R8: exactly 9 zeros split across spans
        fill_sector(0, 0);
        for (int k = 0; k < 6; k++) sec[k * 70][0] = 1'b0;
        for (int k = 0; k < 3; k++) sec[NDATA + k][1] = 1'b0;
        run_sector(31, 0, "nine split");
        // R3: heavy zeros, tallies must saturate not wrap
        for (int i = 0; i < NBYTES; i++) sec[i] = 8'h00;
        run_sector(15, 5, "all zeros");
        // R3: zeros exceed limit in code span alone
        fill_sector(0, 0);
        for (int i = NDATA; i < NBYTES; i++) sec[i] = 8'h0F;
        run_sector(9, 0, "code saturate");

        // R2: unarmed start, bytes ignored, no verdict
        fill_sector(2, 0);
        pulse_start(8);
        stream(NBYTES, 0, sp);
        chk(sp == 0 && !verdict_valid, "R2 no verdict when unarmed", sp, 0);
        repeat (3) @(negedge clk);
        chk(!verdict_valid, "R2 still idle", int'(verdict_valid), 0);

        // R9: abandon mid-sector, then clean sector must report zero
        for (int i = 0; i < NBYTES; i++) sec[i] = 8'h00;
        pulse_start(10);
        stream(200, 0, sp);
        chk(sp == 0, "R9 no verdict on abandoned sector", sp, 0);
        fill_sector(0, 0);
        run_sector(10, 0, "restart clean");
        // R9: disarm mid-sector
        pulse_start(10);
        stream(100, 0, sp);
        pulse_start(3);
        stream(NBYTES, 0, sp);
        chk(sp == 0 && !verdict_valid, "R9 R2 disarm mid-sector", sp, 0);

        // random mix: R4 gaps, R6 R7 R8 decisions
        for (int t = 0; t < 40; t++) begin
            fill_sector($urandom_range(9, 0), $urandom_range(4, 0));
            run_sector($urandom_range(31, 9), $urandom_range(30, 0), "random");
        end

        finish_run();
    end
endmodule